// File: doc/BRIEF.md
# Dual MII Cut-Through Bridge

This block connects two full-duplex MII ports, A and B, so that traffic passes from each one to the other with a short, fixed delay. One lane takes the receive nibble and data-valid of A and drives the transmit nibble and enable of B. A second, identical lane carries B's receive stream to A's transmit outputs. A typical place for it is between a protected segment and an external one, where a decision made elsewhere may need to spoil a frame while it is still in flight.

All logic runs on one fast system clock, at least five times the MII clock. Each MII clock goes through a synchronizer and an edge detector. The receive nibble and valid bit are latched a fixed number of fast cycles after the receive clock rises, so the sample falls near the middle of the bit period. Line skew and edge glitches are over by then. The latched beat then enters a four-slot ring. The ring is written on each receive clock rise and read on each transmit clock rise. The read pointer starts one slot behind the write pointer, and because both MII clocks run at the same nominal rate the two pointers never meet, so the ring has no flow control.

Each destination port has a block request input. When a block request is seen while a valid nibble is leaving the ring, the bridge raises transmit error toward that port for the rest of the frame.

Top module: `mii_dual_bridge`

## Requirements
- R1: Receive nibble and data-valid of port A appear on transmit nibble and enable of port B, bit for bit, and the same holds from port B to port A. Receive data bit i maps to transmit data bit i, and data-valid maps to transmit enable.
- R2: Receive and transmit cycles are each counted from the first clock rise after reset, and each transmit clock rise follows the matching receive clock rise by less than one MII period. Under that condition, the nibble presented in receive cycle n is driven on the opposite port after transmit clock rise n+2. The attached PHY therefore takes it at rise n+3, three MII clocks after it arrived.
- R3: The receive nibble and data-valid are latched on the fourth fast-clock rising edge after the first fast edge that sees the receive clock high. Any value on those lines during the first fast-clock period after the receive clock rise has no effect on what is forwarded.
- R4: Transmit nibble, enable and error change only on the second fast-clock rising edge after the first fast edge that sees the transmit clock high.
- R5: While reset is low, and for transmit rises 0 and 1 after it, each transmit port drives nibble 0 with enable and error low.
- R6: Each lane's ring has four slots. The read pointer starts one slot behind the write pointer, and the ring never runs empty when both MII clocks share one rate. No nibble is lost or repeated.
- R7: A block request that is high at a transmit clock rise that forwards a valid nibble raises transmit error with that nibble. Error then stays high for every following nibble of the same frame and drops when enable drops. Nibble and enable are unchanged.
- R8: A block request that is high only at transmit rises that forward no valid nibble has no effect on any later frame.
- R9: The two lanes work at the same time and independently, so frames may overlap in both directions.
- R10: Transmit error is never high while transmit enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Fast sampling clock, at least five times the MII clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_rx_clk | input | 1 | Port A receive clock |
| a_rxd | input | 4 | Port A receive nibble |
| a_rx_dv | input | 1 | Port A receive data valid |
| a_tx_clk | input | 1 | Port A transmit clock |
| a_txd | output | 4 | Port A transmit nibble, carrying port B receive data |
| a_tx_en | output | 1 | Port A transmit enable |
| a_tx_er | output | 1 | Port A transmit error |
| blk_to_a | input | 1 | Block request for frames heading to port A |
| b_rx_clk | input | 1 | Port B receive clock |
| b_rxd | input | 4 | Port B receive nibble |
| b_rx_dv | input | 1 | Port B receive data valid |
| b_tx_clk | input | 1 | Port B transmit clock |
| b_txd | output | 4 | Port B transmit nibble, carrying port A receive data |
| b_tx_en | output | 1 | Port B transmit enable |
| b_tx_er | output | 1 | Port B transmit error |
| blk_to_b | input | 1 | Block request for frames heading to port B |

## Verification
A block request can arrive at the same transmit clock rise that forwards the first nibble of a frame, or the last one, or the only nibble of a one-nibble frame. These are the cases where the sticky error flag must start and stop in the same transmit cycle. The bench raises the request for exactly one transmit period at each of these points. It expects error on the whole frame, on the final nibble alone, and on the single nibble alone, each cleared with enable. A second meeting point is a ring write and a ring read on nearby fast cycles in each lane, with frames overlapping in both directions. A behavioural queue model judges that the nibble stream and the enable envelope come out exactly, on every fast clock.

// File: rtl/mii_bridge_pkg.sv
package mii_bridge_pkg;

    localparam int NIB_W = 4;

    // One MII beat: data-valid plus nibble
    typedef struct packed {
        logic             dv;
        logic [NIB_W-1:0] nib;
    } mii_beat_t;

endpackage

// File: rtl/mii_edge_det.sv
// Brings a slow MII clock into the fast domain and flags its rising edge.
module mii_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mii_clk_i,
    output logic rise_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], mii_clk_i};
        st_d.last = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync[SYNC_STAGES-1] & ~st_q.last;

endmodule

// File: rtl/mii_mid_sampler.sv
// Latches the receive beat a fixed number of fast cycles after the clock rise.
module mii_mid_sampler
    import mii_bridge_pkg::*;
#(
    parameter int SAMPLE_DLY = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_i,
    input  mii_beat_t beat_i,
    output mii_beat_t beat_o
);

    typedef struct packed {
        logic [SAMPLE_DLY-1:0] wait_sr;
        mii_beat_t             held;
    } smp_st_t;

    smp_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wait_sr = {st_q.wait_sr[SAMPLE_DLY-2:0], rise_i};
        if (st_q.wait_sr[SAMPLE_DLY-1]) begin
            st_d.held = beat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_o = st_q.held;

endmodule

// File: rtl/mii_ring_xfer.sv
// Ring between receive and transmit timing, plus the sticky error flag.
module mii_ring_xfer
    import mii_bridge_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  mii_beat_t        wbeat_i,
    input  logic             rd_i,
    input  logic             blk_i,
    output logic [NIB_W-1:0] txd_o,
    output logic             tx_en_o,
    output logic             tx_er_o,
    output logic [PTR_W-1:0] fill_o
);

    typedef struct packed {
        mii_beat_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]      wp;
        logic [PTR_W-1:0]      rp;
        mii_beat_t             out;
        logic                  er;
    } ring_st_t;

    localparam ring_st_t RING_RST = '{
        slot: '0,
        wp:   PTR_W'(1),
        rp:   '0,
        out:  '0,
        er:   1'b0
    };

    ring_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.slot[st_q.wp] = wbeat_i;
            st_d.wp            = st_q.wp + PTR_W'(1);
        end
        if (rd_i) begin
            st_d.out = st_q.slot[st_q.rp];
            st_d.rp  = st_q.rp + PTR_W'(1);
            st_d.er  = st_q.slot[st_q.rp].dv & (blk_i | st_q.er);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RING_RST;
        else        st_q <= st_d;
    end

    assign txd_o   = st_q.out.nib;
    assign tx_en_o = st_q.out.dv;
    assign tx_er_o = st_q.er;
    assign fill_o  = st_q.wp - st_q.rp;

endmodule

// File: rtl/mii_bridge_lane.sv
// One direction: receive port of one side to transmit port of the other.
module mii_bridge_lane
    import mii_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_DLY  = 2,
    parameter int RING_DEPTH  = 4,
    localparam int PTR_W = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_clk_i,
    input  logic [NIB_W-1:0] rxd_i,
    input  logic             rx_dv_i,
    input  logic             tx_clk_i,
    input  logic             blk_i,
    output logic [NIB_W-1:0] txd_o,
    output logic             tx_en_o,
    output logic             tx_er_o,
    output logic [PTR_W-1:0] fill_o
);

    logic      rx_rise, tx_rise;
    mii_beat_t raw_beat, mid_beat;

    assign raw_beat = '{dv: rx_dv_i, nib: rxd_i};

    mii_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_rx_edge (
        .clk(clk), .rst_n(rst_n), .mii_clk_i(rx_clk_i), .rise_o(rx_rise)
    );

    mii_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_tx_edge (
        .clk(clk), .rst_n(rst_n), .mii_clk_i(tx_clk_i), .rise_o(tx_rise)
    );

    mii_mid_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
        .clk(clk), .rst_n(rst_n), .rise_i(rx_rise),
        .beat_i(raw_beat), .beat_o(mid_beat)
    );

    mii_ring_xfer #(.DEPTH(RING_DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_i(rx_rise), .wbeat_i(mid_beat),
        .rd_i(tx_rise), .blk_i(blk_i),
        .txd_o(txd_o), .tx_en_o(tx_en_o), .tx_er_o(tx_er_o),
        .fill_o(fill_o)
    );

endmodule

// File: rtl/mii_dual_bridge.sv
// Two cut-through lanes: A receive to B transmit, B receive to A transmit.
module mii_dual_bridge
    import mii_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_DLY  = 2,
    parameter int RING_DEPTH  = 4
) (
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             a_rx_clk,
    input  logic [NIB_W-1:0] a_rxd,
    input  logic             a_rx_dv,
    input  logic             a_tx_clk,
    output logic [NIB_W-1:0] a_txd,
    output logic             a_tx_en,
    output logic             a_tx_er,
    input  logic             blk_to_a,
    input  logic             b_rx_clk,
    input  logic [NIB_W-1:0] b_rxd,
    input  logic             b_rx_dv,
    input  logic             b_tx_clk,
    output logic [NIB_W-1:0] b_txd,
    output logic             b_tx_en,
    output logic             b_tx_er,
    input  logic             blk_to_b
);

    localparam int LANES = 2;
    localparam int PTR_W = $clog2(RING_DEPTH);

    // Lane 0 carries A to B, lane 1 carries B to A
    logic [LANES-1:0] src_rx_clk, src_rx_dv, dst_tx_clk, dst_blk;
    logic [LANES-1:0] dst_tx_en, dst_tx_er;
    logic [NIB_W-1:0] src_rxd   [LANES];
    logic [NIB_W-1:0] dst_txd   [LANES];
    logic [PTR_W-1:0] lane_fill [LANES];

    assign src_rx_clk = {b_rx_clk, a_rx_clk};
    assign src_rx_dv  = {b_rx_dv,  a_rx_dv};
    assign dst_tx_clk = {a_tx_clk, b_tx_clk};
    assign dst_blk    = {blk_to_a, blk_to_b};
    assign src_rxd[0] = a_rxd;
    assign src_rxd[1] = b_rxd;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mii_bridge_lane #(
            .SYNC_STAGES(SYNC_STAGES),
            .SAMPLE_DLY (SAMPLE_DLY),
            .RING_DEPTH (RING_DEPTH)
        ) u_lane (
            .clk     (clk_sys),
            .rst_n   (rst_n),
            .rx_clk_i(src_rx_clk[g]),
            .rxd_i   (src_rxd[g]),
            .rx_dv_i (src_rx_dv[g]),
            .tx_clk_i(dst_tx_clk[g]),
            .blk_i   (dst_blk[g]),
            .txd_o   (dst_txd[g]),
            .tx_en_o (dst_tx_en[g]),
            .tx_er_o (dst_tx_er[g]),
            .fill_o  (lane_fill[g])
        );
    end

    assign b_txd   = dst_txd[0];
    assign b_tx_en = dst_tx_en[0];
    assign b_tx_er = dst_tx_er[0];
    assign a_txd   = dst_txd[1];
    assign a_tx_en = dst_tx_en[1];
    assign a_tx_er = dst_tx_er[1];

endmodule

// File: rtl/mii_dual_bridge_chk.sv
module mii_dual_bridge_chk #(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_tx_clk,
    input logic [3:0]       a_txd,
    input logic             a_tx_en,
    input logic             a_tx_er,
    input logic             b_tx_clk,
    input logic [3:0]       b_txd,
    input logic             b_tx_en,
    input logic             b_tx_er,
    input logic [PTR_W-1:0] fill_ab,
    input logic [PTR_W-1:0] fill_ba
);

    AST_ER_NEEDS_EN_A: assert property (@(posedge clk) disable iff (!rst_n) a_tx_er |-> a_tx_en); // R10
    AST_ER_NEEDS_EN_B: assert property (@(posedge clk) disable iff (!rst_n) b_tx_er |-> b_tx_en); // R10

    AST_TX_ON_EDGE_A: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({a_txd, a_tx_en, a_tx_er}) |-> $past(a_tx_clk, 2)); // R4
    AST_TX_ON_EDGE_B: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({b_txd, b_tx_en, b_tx_er}) |-> $past(b_tx_clk, 2)); // R4

    AST_ER_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_tx_er) && a_tx_en |-> a_tx_er); // R7
    AST_ER_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(b_tx_er) && b_tx_en |-> b_tx_er); // R7

    AST_RING_GAP_AB: assert property (@(posedge clk) disable iff (!rst_n) fill_ab != '0); // R6
    AST_RING_GAP_BA: assert property (@(posedge clk) disable iff (!rst_n) fill_ba != '0); // R6

endmodule

bind mii_dual_bridge mii_dual_bridge_chk #(.PTR_W(PTR_W)) u_chk (
    .clk     (clk_sys),
    .rst_n   (rst_n),
    .a_tx_clk(a_tx_clk),
    .a_txd   (a_txd),
    .a_tx_en (a_tx_en),
    .a_tx_er (a_tx_er),
    .b_tx_clk(b_tx_clk),
    .b_txd   (b_txd),
    .b_tx_en (b_tx_en),
    .b_tx_er (b_tx_er),
    .fill_ab (lane_fill[0]),
    .fill_ba (lane_fill[1])
);

// File: tb/test_mii_dual_bridge.sv
module test_mii_dual_bridge;

    localparam int T_END   = 1100;
    localparam int RX_OFF0 = 0, TX_OFF0 = 3;   // lane A->B
    localparam int RX_OFF1 = 1, TX_OFF1 = 5;   // lane B->A

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rxc, rxdv, txc, blk;
    logic [3:0] rxd [2];
    logic [3:0] a_txd, b_txd;
    logic       a_tx_en, a_tx_er, b_tx_en, b_tx_er;

    always #5 clk = ~clk;

    mii_dual_bridge i_mii_dual_bridge (
        .clk_sys(clk), .rst_n(rst_n),
        .a_rx_clk(rxc[0]), .a_rxd(rxd[0]), .a_rx_dv(rxdv[0]), .a_tx_clk(txc[1]),
        .a_txd(a_txd), .a_tx_en(a_tx_en), .a_tx_er(a_tx_er), .blk_to_a(blk[1]),
        .b_rx_clk(rxc[1]), .b_rxd(rxd[1]), .b_rx_dv(rxdv[1]), .b_tx_clk(txc[0]),
        .b_txd(b_txd), .b_tx_en(b_tx_en), .b_tx_er(b_tx_er), .blk_to_b(blk[0])
    );

    int    vectors = 0, fails = 0, both_busy = 0;
    int    en_seen [2];
    bit    done = 1'b0;
    logic [5:0] q0 [$];
    logic [5:0] q1 [$];
    logic [3:0] e_d [2];
    logic       e_en [2], e_er [2];
    logic [3:0] p_d [2];
    logic       p_en [2], p_er [2];
    int         p_t [2];
    string      e_tag [2], p_tag [2];
    logic [4:0] cur [2];

    // {dv, nibble} offered by each source in receive cycle n
    function automatic logic [4:0] beat(input int dir, input int n);
        logic dv;
        logic [3:0] d;
        if (dir == 0) begin
            dv = (n >= 3) && ((n % 23) < 15 || (n % 23) == 17);
            d  = 4'((n * 7 + 3) % 16);
        end else begin
            dv = (n >= 5) && ((n % 19) < 9 || (n % 19) == 11 || (n % 19) == 12);
            d  = 4'((n * 5 + n / 4) % 16);
        end
        return {dv, d};
    endfunction

    function automatic bit blk_on(input int dir, input int j);
        if (dir == 0) return (j == 32 || j == 33 || j == 66 || j == 94 || j == 108 || j == 111);
        return (j == 30 || j == 60);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [5:0] outs(input int p);
        return (p == 0) ? {b_tx_en, b_tx_er, b_txd} : {a_tx_en, a_tx_er, a_txd};
    endfunction

    initial begin
        rst_n = 1'b0;
        rxc = '0; rxdv = '0; txc = '0; blk = '0;
        rxd[0] = '0; rxd[1] = '0;
        for (int p = 0; p < 2; p++) begin
            e_d[p] = '0; e_en[p] = 1'b0; e_er[p] = 1'b0; e_tag[p] = "R5";
            p_t[p] = -1; en_seen[p] = 0; cur[p] = '0;
        end
        repeat (5) @(negedge clk);
        // R5: reset state of both transmit ports
        check(outs(0) == 6'h0, "R5", "port B outputs in reset", outs(0), 0);
        check(outs(1) == 6'h0, "R5", "port A outputs in reset", outs(1), 0);
        rst_n = 1'b1;

        for (int t = 0; t < T_END; t++) begin
            @(negedge clk);
            for (int p = 0; p < 2; p++) begin
                if (p_t[p] == t) begin
                    e_d[p] = p_d[p]; e_en[p] = p_en[p]; e_er[p] = p_er[p]; e_tag[p] = p_tag[p];
                end
            end
            // compare every fast clock
            for (int p = 0; p < 2; p++) begin
                logic [5:0] act, exp;
                string tag;
                int ph;
                act = outs(p);
                exp = {e_en[p], e_er[p], e_d[p]};
                ph  = t - ((p == 0) ? TX_OFF0 : TX_OFF1);
                if (act[4] != exp[4]) tag = "R7";
                else if (ph >= 0 && (ph % 8 == 2 || ph % 8 == 3)) tag = "R4";
                else tag = e_tag[p];
                check(act == exp, tag, (p == 0) ? "A->B {en,er,txd}" : "B->A {en,er,txd}", act, exp);
                // R10: error only with enable
                check(!(act[4] && !act[5]), "R10", "tx_er without tx_en", act, exp);
            end
            if (a_tx_en && b_tx_en) both_busy++;

            for (int dir = 0; dir < 2; dir++) begin
                int pr, px;
                pr = t - ((dir == 0) ? RX_OFF0 : RX_OFF1);
                px = t - ((dir == 0) ? TX_OFF0 : TX_OFF1);
                if (pr >= 0) begin
                    rxc[dir] = (pr % 8) < 4;
                    if (pr % 8 == 0) begin
                        int n;
                        bit sk;
                        n  = pr / 8;
                        sk = (n % 3 == 0);
                        cur[dir] = beat(dir, n);
                        if (dir == 0) q0.push_back({sk, cur[dir]});
                        else          q1.push_back({sk, cur[dir]});
                        // R3: wrong value for the first fast period after the rise
                        {rxdv[dir], rxd[dir]} = sk ? ~cur[dir] : cur[dir];
                    end else if (pr % 8 == 1) begin
                        {rxdv[dir], rxd[dir]} = cur[dir];
                    end
                end
                if (px >= 0) begin
                    txc[dir] = (px % 8) < 4;
                    if (px % 8 == 0) begin
                        int j;
                        logic [5:0] e;
                        j = px / 8;
                        if (outs(dir)[5]) en_seen[dir]++;
                        // dedicated checks on what the previous rise delivered
                        if (j == 11) begin
                            // R1: nibble 8 of the source, bit for bit
                            check(outs(dir) == {1'b1, 1'b0, beat(dir, 8)[3:0]}, "R1",
                                  "mapping of receive nibble 8", outs(dir), {2'b10, beat(dir, 8)[3:0]});
                        end
                        if (dir == 0 && j == 35)
                            check(b_tx_er == 1'b1, "R7", "error after mid-frame block", b_tx_er, 1);
                        if (dir == 0 && j == 72)
                            check(b_tx_en && !b_tx_er, "R8", "idle block leaked into frame", {b_tx_en, b_tx_er}, 2'b10);
                        if (dir == 0 && j == 95)
                            check(b_tx_en && b_tx_er, "R7", "block on first nibble", {b_tx_en, b_tx_er}, 2'b11);
                        if (dir == 0 && j == 109)
                            check(b_tx_en && b_tx_er, "R7", "block on last nibble", {b_tx_en, b_tx_er}, 2'b11);
                        if (dir == 0 && j == 110)
                            check(!b_tx_en && !b_tx_er, "R7", "error after frame end", {b_tx_en, b_tx_er}, 2'b00);
                        if (dir == 0 && j == 112)
                            check(b_tx_en && b_tx_er, "R7", "block on one-nibble frame", {b_tx_en, b_tx_er}, 2'b11);
                        // reference model: nibble j-2 leaves at rise j
                        if (j >= 2) e = (dir == 0) ? q0.pop_front() : q1.pop_front();
                        else        e = '0;
                        p_d[dir]   = e[3:0];
                        p_en[dir]  = e[4];
                        p_er[dir]  = e[4] & (blk[dir] | e_er[dir]);
                        p_tag[dir] = (j < 2) ? "R5" : (e[5] ? "R3" : "R2");
                        p_t[dir]   = t + 3;
                    end else if (px % 8 == 6) begin
                        blk[dir] = blk_on(dir, px / 8 + 1);
                    end
                end
            end
        end

        // R6: every valid nibble offered came out exactly once
        for (int dir = 0; dir < 2; dir++) begin
            int last_rise, want;
            last_rise = (T_END - 1 - ((dir == 0) ? TX_OFF0 : TX_OFF1)) / 8;
            want = 0;
            for (int n = 0; n <= last_rise - 3; n++) if (beat(dir, n)[4]) want++;
            check(en_seen[dir] == want, "R6", "count of forwarded valid nibbles", en_seen[dir], want);
        end
        // R9: both lanes carried frames at the same time
        check(both_busy > 0, "R9", "overlap of both directions", both_busy, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule